// File: doc/BRIEF.md
# Selectable-Edge External Interrupt Front End

This block takes four asynchronous external pins and turns chosen transitions on them into interrupt request pulses, one request line per pin. Every pin first goes through a two-stage synchronizer. A small per-channel state machine then remembers the last synchronized level it saw. A change between that remembered level and the fresh synchronized level is an edge. The edge raises the channel's request only if the channel's configuration allows that direction.

Two 8-bit control registers hold the configuration. One holds the rising-enable bits and one holds the falling-enable bits. Channel n uses bit n of each register. The pair of bits gives each channel one of four modes: off, falling only, rising only, or both edges. A simple bus can write a whole byte, set or clear a single bit, and read either register back. Priority, masking and vectoring are left to a downstream controller.

Each channel state machine has two states. `LVL_LOW` means the last synchronized level was 0. `LVL_HIGH` means it was 1. The transition `LVL_LOW -> LVL_HIGH` is taken when the synchronized pin is 1. The transition `LVL_HIGH -> LVL_LOW` is taken when it is 0. Otherwise the state holds. These transitions happen whatever the mode is. The rise transition raises the request in modes rising-only and both. The fall transition raises it in modes falling-only and both. The mode is decoded from the bit pair {rise, fall}: `MODE_OFF` = 00, `MODE_FALL` = 01, `MODE_RISE` = 10, `MODE_BOTH` = 11.

Top module: `edge_irq_frontend`

## Requirements
- R1: There are four channels, 0 to 3. Channel n drives request output `irq_o[n]` and watches pin `pin_i[n]`.
- R2: With rise bit n = 0 and fall bit n = 1, channel n pulses only on falling transitions of its pin.
- R3: With rise bit n = 1 and fall bit n = 0, channel n pulses only on rising transitions of its pin.
- R4: With both bits set, every transition of the pin produces exactly one pulse, including when the pin toggles on every clock.
- R5: With both bits clear, channel n never raises its request.
- R6: A pin change that is stable across a clock edge raises the request in the cycle that follows the second clock edge after the change. The request lasts exactly one clock cycle.
- R7: Channel n's enable is bit n of each register. The rising register is at address 0x48 and the falling register at 0x49. Bits 7 to 4 read as 0 and ignore both byte and bit writes. Any other address reads 0x00.
- R8: After reset both registers read 0x00 and no request is raised.
- R9: A bit write (`bus_bitop_i`=1) sets bit `bus_bitidx_i` of the addressed register to `bus_bitval_i` and leaves all other bits unchanged. A byte write (`bus_bitop_i`=0) loads `bus_wdata_i`.
- R10: From the cycle after a write clears both bits of a channel, that channel raises no request, even for an edge that is already in flight.
- R11: The remembered level keeps following the pin while the channel is off. Enabling a channel after its pin has changed level gives no pulse.
- R12: An edge that is seen in the same cycle as a register write is judged with the register contents from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_i | input | 4 | Asynchronous external pins |
| bus_wr_i | input | 1 | Register write strobe |
| bus_bitop_i | input | 1 | 1 = single-bit write, 0 = byte write |
| bus_addr_i | input | 8 | Register address |
| bus_wdata_i | input | 8 | Byte write data |
| bus_bitidx_i | input | 3 | Bit index for a single-bit write |
| bus_bitval_i | input | 1 | Value for a single-bit write |
| bus_rdata_o | output | 8 | Read data for `bus_addr_i` (combinational) |
| irq_o | output | 4 | One-cycle interrupt request per channel |

## Verification
Suppose a channel's remembered level goes wrong. It then shows at `irq_o` within one cycle of the next pin event. The symptom is either a pulse with no real transition, or a missing pulse, and it also appears right after the channel is enabled. A corrupt enable bit shows up on the next read of its register, and also as a pulse on the wrong direction of edge. The bench compares every request line and the read data with a behavioural model on every clock. So each of these faults is seen in the first cycle it reaches a port.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;

    localparam int unsigned EIQ_CHANNELS  = 4;
    localparam int unsigned EIQ_DATA_W    = 8;
    localparam int unsigned EIQ_ADDR_W    = 8;
    localparam int unsigned EIQ_SYNC_DEPTH = 2;
    localparam logic [EIQ_ADDR_W-1:0] EIQ_RISE_ADDR = 8'h48;
    localparam logic [EIQ_ADDR_W-1:0] EIQ_FALL_ADDR = 8'h49;

    // Remembered level of one synchronized pin
    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_state_e;

    // Edge mode, encoded as {rise, fall}
    typedef enum logic [1:0] {
        MODE_OFF  = 2'b00,
        MODE_FALL = 2'b01,
        MODE_RISE = 2'b10,
        MODE_BOTH = 2'b11
    } edge_mode_e;

    function automatic edge_mode_e decode_mode(input logic rise_en, input logic fall_en);
        edge_mode_e m;
        unique case ({rise_en, fall_en})
            2'b00:   m = MODE_OFF;
            2'b01:   m = MODE_FALL;
            2'b10:   m = MODE_RISE;
            default: m = MODE_BOTH;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/edge_irq_sync.sv
module edge_irq_sync #(
    parameter int unsigned WIDTH = 4,
    parameter int unsigned DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q[0] <= '0;
        end else begin
            stage_q[0] <= async_i;
        end
    end

    // Further stages of the chain
    for (genvar s = 1; s < DEPTH; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[s] <= '0;
            end else begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_o = stage_q[DEPTH-1];

endmodule

// File: rtl/edge_irq_regs.sv
module edge_irq_regs
    import edge_irq_pkg::*;
#(
    parameter int unsigned NCH    = EIQ_CHANNELS,
    parameter int unsigned DATA_W = EIQ_DATA_W,
    parameter int unsigned ADDR_W = EIQ_ADDR_W,
    parameter logic [ADDR_W-1:0] RISE_ADDR = EIQ_RISE_ADDR,
    parameter logic [ADDR_W-1:0] FALL_ADDR = EIQ_FALL_ADDR
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_i,
    input  logic                      bitop_i,
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic [DATA_W-1:0]         wdata_i,
    input  logic [$clog2(DATA_W)-1:0] bitidx_i,
    input  logic                      bitval_i,
    output logic [DATA_W-1:0]         rdata_o,
    output logic [NCH-1:0]            rise_en_o,
    output logic [NCH-1:0]            fall_en_o
);

    localparam int unsigned IDX_W  = $clog2(DATA_W);
    localparam int unsigned NREG   = 2;
    localparam int unsigned PAD_W  = DATA_W - NCH;

    logic [ADDR_W-1:0] reg_addr [NREG];
    logic [NCH-1:0]    reg_q    [NREG];
    logic [NCH-1:0]    reg_d    [NREG];
    logic [NREG-1:0]   hit;

    assign reg_addr[0] = RISE_ADDR;
    assign reg_addr[1] = FALL_ADDR;

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        assign hit[r] = (addr_i == reg_addr[r]);

        always_comb begin
            reg_d[r] = reg_q[r];
            if (wr_i && hit[r]) begin
                if (bitop_i) begin
                    for (int b = 0; b < NCH; b++) begin
                        if (bitidx_i == IDX_W'(b)) begin
                            reg_d[r][b] = bitval_i;
                        end
                    end
                end else begin
                    reg_d[r] = wdata_i[NCH-1:0];
                end
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                reg_q[r] <= '0;
            end else begin
                reg_q[r] <= reg_d[r];
            end
        end

        // R9: a register changes only under a write addressed to it
        AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_i && hit[r]) |=> $stable(reg_q[r])); // R9
    end

    always_comb begin
        rdata_o = '0;
        for (int r = 0; r < NREG; r++) begin
            if (hit[r]) begin
                rdata_o = {{PAD_W{1'b0}}, reg_q[r]};
            end
        end
    end

    assign rise_en_o = reg_q[0];
    assign fall_en_o = reg_q[1];

endmodule

// File: rtl/edge_irq_chan.sv
module edge_irq_chan
    import edge_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_s_i,
    input  logic rise_en_i,
    input  logic fall_en_i,
    output logic irq_o
);

    lvl_state_e state_q, state_d;
    edge_mode_e mode;

    assign mode = decode_mode(rise_en_i, fall_en_i);

    // Next-state logic: follows the pin in every mode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LVL_LOW:  if (lvl_s_i)  state_d = LVL_HIGH;
            LVL_HIGH: if (!lvl_s_i) state_d = LVL_LOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LVL_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // Output logic: the taken transition qualified by the mode
    always_comb begin
        irq_o = 1'b0;
        unique case (state_q)
            LVL_LOW:  irq_o = lvl_s_i  && (mode == MODE_RISE || mode == MODE_BOTH);
            LVL_HIGH: irq_o = !lvl_s_i && (mode == MODE_FALL || mode == MODE_BOTH);
        endcase
    end

    AST_RISE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && mode == MODE_RISE) |-> lvl_s_i); // R3
    AST_FALL_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && mode == MODE_FALL) |-> !lvl_s_i); // R2
    AST_HIST_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((state_q == LVL_HIGH) == $past(lvl_s_i))); // R11

endmodule

// File: rtl/edge_irq_frontend.sv
module edge_irq_frontend
    import edge_irq_pkg::*;
#(
    parameter int unsigned NCH    = EIQ_CHANNELS,
    parameter int unsigned DATA_W = EIQ_DATA_W,
    parameter int unsigned ADDR_W = EIQ_ADDR_W,
    parameter int unsigned SYNC_DEPTH = EIQ_SYNC_DEPTH
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NCH-1:0]            pin_i,
    input  logic                      bus_wr_i,
    input  logic                      bus_bitop_i,
    input  logic [ADDR_W-1:0]         bus_addr_i,
    input  logic [DATA_W-1:0]         bus_wdata_i,
    input  logic [$clog2(DATA_W)-1:0] bus_bitidx_i,
    input  logic                      bus_bitval_i,
    output logic [DATA_W-1:0]         bus_rdata_o,
    output logic [NCH-1:0]            irq_o
);

    logic [NCH-1:0] pin_s;
    logic [NCH-1:0] rise_en;
    logic [NCH-1:0] fall_en;

    edge_irq_sync #(
        .WIDTH (NCH),
        .DEPTH (SYNC_DEPTH)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_i),
        .sync_o  (pin_s)
    );

    edge_irq_regs #(
        .NCH    (NCH),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (bus_wr_i),
        .bitop_i   (bus_bitop_i),
        .addr_i    (bus_addr_i),
        .wdata_i   (bus_wdata_i),
        .bitidx_i  (bus_bitidx_i),
        .bitval_i  (bus_bitval_i),
        .rdata_o   (bus_rdata_o),
        .rise_en_o (rise_en),
        .fall_en_o (fall_en)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_chan
        edge_irq_chan u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .lvl_s_i   (pin_s[n]),
            .rise_en_i (rise_en[n]),
            .fall_en_i (fall_en[n]),
            .irq_o     (irq_o[n])
        );

        AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
            (!rise_en[n] && !fall_en[n]) |-> !irq_o[n]); // R10
    end

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata_o[DATA_W-1:NCH] == '0); // R7

endmodule

// File: tb/edge_irq_frontend_bench.sv
module edge_irq_frontend_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] pin = '0;
    logic       wr = 1'b0;
    logic       bitop = 1'b0;
    logic [7:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [2:0] bitidx = '0;
    logic       bitval = 1'b0;
    logic [7:0] rdata;
    logic [3:0] irq;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;
    string phase = "R8";

    always #5 clk = ~clk;

    edge_irq_frontend u_edge_irq_frontend (
        .clk          (clk),
        .rst_n        (rst_n),
        .pin_i        (pin),
        .bus_wr_i     (wr),
        .bus_bitop_i  (bitop),
        .bus_addr_i   (addr),
        .bus_wdata_i  (wdata),
        .bus_bitidx_i (bitidx),
        .bus_bitval_i (bitval),
        .bus_rdata_o  (rdata),
        .irq_o        (irq)
    );

    // Behavioural model: pin samples taken at each edge, plus register images
    bit samples[$];
    bit [3:0] pin_samples[$];
    bit [3:0] m_rise = '0;
    bit [3:0] m_fall = '0;

    function automatic string mode_tag(bit r, bit f);
        if (r && f) return "R4,R6";
        if (r)      return "R3,R6";
        if (f)      return "R2,R6";
        return "R5";
    endfunction

    task automatic check(string req, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s (phase %s) t=%0t actual=%0h expected=%0h", req, phase, $time, act, exp);
        end
    endtask

    initial begin
        pin_samples = '{4'h0, 4'h0, 4'h0};
    end

    // Compare pre-edge values, then advance the model
    always @(posedge clk) begin
        bit [3:0] cur;
        bit [3:0] prev;
        bit [7:0] exp_rd;
        cur  = pin_samples[1];
        prev = pin_samples[0];
        for (int n = 0; n < 4; n++) begin
            bit e;
            e = rst_n && (cur[n] != prev[n]) && (cur[n] ? m_rise[n] : m_fall[n]);
            check($sformatf("R1 ch%0d %s", n, mode_tag(m_rise[n], m_fall[n])), irq[n], e);
        end
        exp_rd = (addr == 8'h48) ? {4'h0, m_rise} : (addr == 8'h49) ? {4'h0, m_fall} : 8'h00;
        check("R7 read", rdata, exp_rd);
        if (!rst_n) begin
            pin_samples = '{4'h0, 4'h0, 4'h0};
            m_rise = '0;
            m_fall = '0;
        end else begin
            void'(pin_samples.pop_front());
            pin_samples.push_back(pin);
            if (wr && (addr == 8'h48 || addr == 8'h49)) begin
                bit [3:0] img;
                img = (addr == 8'h48) ? m_rise : m_fall;
                if (bitop) begin
                    if (bitidx < 3'd4) img[bitidx] = bitval;
                end else begin
                    img = wdata[3:0];
                end
                if (addr == 8'h48) m_rise = img; else m_fall = img;
            end
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_byte(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        wr = 1'b1; bitop = 1'b0; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic wr_bit(logic [7:0] a, logic [2:0] i, logic v);
        @(negedge clk);
        wr = 1'b1; bitop = 1'b1; addr = a; bitidx = i; bitval = v;
        @(negedge clk);
        wr = 1'b0; bitop = 1'b0;
    endtask

    task automatic drive_pin(logic [3:0] v);
        @(negedge clk);
        pin = v;
    endtask

    initial begin
        #200000ns;
        if (!finished) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        // R8: reset state
        idle(3);
        rst_n = 1'b1;
        addr = 8'h48; idle(2);
        addr = 8'h49; idle(2);

        // R7: upper bits ignored, other addresses read zero
        phase = "R7";
        wr_byte(8'h48, 8'hF0);
        wr_byte(8'h49, 8'hA0);
        wr_bit(8'h48, 3'd6, 1'b1);
        addr = 8'h50; idle(2);
        addr = 8'h47; idle(2);

        // R2 R3 R4 R5: ch0 off, ch1 fall, ch2 rise, ch3 both
        phase = "R2,R3,R4,R5";
        wr_byte(8'h48, 8'h0C);
        wr_byte(8'h49, 8'h0A);
        drive_pin(4'hF); idle(4);
        drive_pin(4'h0); idle(4);
        drive_pin(4'h5); idle(3);
        drive_pin(4'hA); idle(5);
        // R4: pin toggling every clock in both mode
        phase = "R4 fast";
        for (int i = 0; i < 8; i++) drive_pin(pin ^ 4'h8);
        idle(4);

        // R9: single-bit writes
        phase = "R9";
        wr_bit(8'h49, 3'd0, 1'b1);
        wr_bit(8'h48, 3'd3, 1'b0);
        wr_bit(8'h48, 3'd1, 1'b1);
        addr = 8'h48; idle(2);
        addr = 8'h49; idle(2);

        // R10: clear ch2 while its edge is in flight
        phase = "R10";
        wr_byte(8'h48, 8'h04); wr_byte(8'h49, 8'h00);
        drive_pin(4'h0); idle(4);
        @(negedge clk); pin = 4'h4;
        @(negedge clk); wr = 1'b1; bitop = 1'b0; addr = 8'h48; wdata = 8'h00;
        @(negedge clk); wr = 1'b0;
        idle(4);

        // R11: level changes while off, then enable: no pulse
        phase = "R11";
        drive_pin(4'hF); idle(4);
        wr_byte(8'h48, 8'h0F); wr_byte(8'h49, 8'h0F);
        idle(4);
        drive_pin(4'h0); idle(4);

        // R12: write lands in the same cycle the edge is judged
        phase = "R12";
        wr_byte(8'h48, 8'h00); wr_byte(8'h49, 8'h00);
        @(negedge clk); pin = 4'h2;
        @(negedge clk);
        @(negedge clk); wr = 1'b1; bitop = 1'b0; addr = 8'h48; wdata = 8'h02;
        @(negedge clk); wr = 1'b0;
        idle(3);
        @(negedge clk); pin = 4'h0;
        @(negedge clk);
        @(negedge clk); wr = 1'b1; bitop = 1'b0; addr = 8'h49; wdata = 8'h02;
        @(negedge clk); wr = 1'b0;
        idle(4);

        // Mixed traffic
        phase = "random";
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (($urandom % 3) == 0) pin = 4'($urandom);
            wr = (($urandom % 8) == 0);
            bitop = 1'($urandom);
            addr = (($urandom % 5) == 0) ? 8'($urandom) : (($urandom % 2) ? 8'h48 : 8'h49);
            wdata = 8'($urandom);
            bitidx = 3'($urandom);
            bitval = 1'($urandom);
        end
        @(negedge clk); wr = 1'b0;
        idle(4);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule